// File: doc/BRIEF.md
# Channelized Request Dispatcher

This block sits between a host write port and nine numbered child units. The host writes a 32-bit request word into a small window of offsets. The low four bits of the word name the target channel. If that child is idle, the word goes out to the child's data slot in the same cycle. If the child is busy, the word is parked in a holding FIFO. The FIFO later releases its entries in arrival order, each one once its child is idle again.

In the other direction, each child raises an availability line while it has a response to give. The block scans those lines from channel 0 upward and pulls one word per cycle from the lowest channel that has data. It writes each pulled word into a return FIFO. Pulling stops whenever the return FIFO is full. The host takes words from the return FIFO with a pop strobe. When the return FIFO holds nothing, the host reads an invalid marker word.

The child side is one shared bus. A child is addressed by its channel number shifted left by four, so each child owns a 16-byte slot. A write strobe, carrying the word, targets the slot's data register. A single-cycle read strobe pulls one response from the slot.

Top module: `chan_req_router`

## Requirements
- R1: A host write is taken as a request only when the address is one of 0xA0, 0xA4, 0xA8 or 0xAC. Any other address, including unaligned ones in the same range, produces no child write and no queued entry.
- R2: A request whose bits [3:0] hold 9 to 15 is dropped. It is neither written to a child nor queued.
- R3: A request to a valid channel whose pend bit is low, arriving while the holding FIFO is not full, is written to the child in the same cycle. The write address is the channel times 16 (channel in address bits [7:4], bits [3:0] zero), and the full 32-bit word is written.
- R4: A request to a valid channel whose pend bit is high is queued in the holding FIFO. No child write happens in that cycle. No child is ever written while its pend bit is high.
- R5: With the holding FIFO full (HOLD_DEPTH entries, default 32), a further request is dropped with no effect. The queued contents are unchanged.
- R6: Queued requests leave the holding FIFO in arrival order. The head entry is written to its child in the first cycle in which that child's pend bit is low and no direct write from R3 is taking place.
- R7: In any cycle in which at least one availability line is high and the return FIFO is not full, exactly one read strobe is issued. It goes to the lowest-numbered channel whose line is high, at address channel times 16. The word on the read data input is pushed into the return FIFO.
- R8: While the return FIFO is full (RET_DEPTH entries, default 32), no read strobe is issued. Pulling resumes once the host pops.
- R9: The return FIFO delivers words in the order they were pulled. While the FIFO is empty, the host data output shows the invalid marker 0x0000000F.
- R10: After reset the return FIFO is empty, the holding FIFO is empty, and neither child strobe is active while all pend and availability lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host write offset |
| host_wdata | input | 32 | Host write word; bits [3:0] pick the channel |
| ret_pop | input | 1 | Host removes the head word of the return FIFO |
| ret_data | output | 32 | Head of the return FIFO, or 0x0000000F when it is empty |
| ret_empty | output | 1 | Return FIFO holds no word |
| ret_full | output | 1 | Return FIFO holds RET_DEPTH words |
| child_pend | input | NUM_CHAN | Per-child busy flag |
| child_avail | input | NUM_CHAN | Per-child response-available line |
| cb_wr | output | 1 | Child bus write strobe |
| cb_waddr | output | 8 | Child bus write address (channel << 4) |
| cb_wdata | output | 32 | Child bus write word |
| cb_rd | output | 1 | Child bus single-cycle read strobe |
| cb_raddr | output | 8 | Child bus read address (channel << 4) |
| cb_rdata | input | 32 | Word returned by the addressed child, valid in the strobe cycle |

## Verification
The assertions assume two things about each child. First, it returns valid data in the same cycle as its read strobe, and that data is never the 0x0F marker. Second, it updates its availability line at the clock edge that ends the strobe, so a line stays high only while more words remain. The bench's child model keeps both promises. It serves each read combinationally from a per-channel response list, advances the list at the clock edge, and derives availability from the remaining count. Pend lines are driven only from the tasks between clock edges, so the same-cycle direct-write checks always see a settled busy flag.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int DATA_W     = 32;
  localparam int CHAN_W     = 4;
  localparam int SLOT_SHIFT = 4;
  localparam int CH_ADDR_W  = CHAN_W + SLOT_SHIFT;
  localparam logic [DATA_W-1:0] INVALID_WORD = 32'h0000_000F;
  localparam logic [CHAN_W-1:0] WINDOW_PAGE  = 4'hA;
  localparam logic [CHAN_W-1:0] WINDOW_LAST  = 4'hC;

  // channel field of a request word
  function automatic logic [CHAN_W-1:0] chan_of(input logic [DATA_W-1:0] word);
    return word[CHAN_W-1:0];
  endfunction

  function automatic logic chan_ok(input logic [CHAN_W-1:0] ch, input int n);
    return int'(ch) < n;
  endfunction

  // child slot address: channel times slot size
  function automatic logic [CH_ADDR_W-1:0] slot_addr(input logic [CHAN_W-1:0] ch);
    return {ch, {SLOT_SHIFT{1'b0}}};
  endfunction

  // word-aligned offsets of the request window
  function automatic logic in_window(input logic [CH_ADDR_W-1:0] addr);
    return (addr[CH_ADDR_W-1:SLOT_SHIFT] == WINDOW_PAGE) &&
           (addr[SLOT_SHIFT-1:0] <= WINDOW_LAST) && (addr[1:0] == 2'b00);
  endfunction
endpackage

// File: rtl/cr_fifo.sv
module cr_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/cr_route.sv
module cr_route
  import cr_pkg::*;
#(
  parameter int NUM_CHAN = 9
) (
  input  logic                 req_hit,
  input  logic [DATA_W-1:0]    req_word,
  input  logic                 hold_full,
  input  logic                 hold_empty,
  input  logic [DATA_W-1:0]    hold_head,
  input  logic [NUM_CHAN-1:0]  child_pend,
  output logic                 queue_push,
  output logic                 direct_wr,
  output logic                 drain_pop,
  output logic                 wr_en,
  output logic [CH_ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0]    wr_data
);
  logic [CHAN_W-1:0] req_ch, head_ch;
  logic              req_ok, req_busy, head_busy, accept;

  always_comb begin
    req_ch    = chan_of(req_word);
    head_ch   = chan_of(hold_head);
    req_ok    = chan_ok(req_ch, NUM_CHAN);
    req_busy  = req_ok ? child_pend[req_ch] : 1'b1;
    head_busy = chan_ok(head_ch, NUM_CHAN) ? child_pend[head_ch] : 1'b1;
    accept     = req_hit && !hold_full && req_ok;
    direct_wr  = accept && !req_busy;
    queue_push = accept && req_busy;
    // a direct write owns the child port; the queue waits a cycle
    drain_pop  = !hold_empty && !head_busy && !direct_wr;
    wr_en      = direct_wr || drain_pop;
    wr_data    = direct_wr ? req_word : hold_head;
    wr_addr    = slot_addr(direct_wr ? req_ch : head_ch);
  end
endmodule

// File: rtl/cr_collect.sv
module cr_collect
  import cr_pkg::*;
#(
  parameter int NUM_CHAN = 9
) (
  input  logic [NUM_CHAN-1:0] child_avail,
  input  logic                ret_full,
  output logic                pull,
  output logic [CHAN_W-1:0]   pull_ch
);
  always_comb begin
    pull_ch = '0;
    for (int i = NUM_CHAN - 1; i >= 0; i--) begin
      if (child_avail[i]) pull_ch = CHAN_W'(i);
    end
    pull = (|child_avail) && !ret_full;
  end
endmodule

// File: rtl/chan_req_router.sv
module chan_req_router
  import cr_pkg::*;
#(
  parameter int NUM_CHAN   = 9,
  parameter int HOLD_DEPTH = 32,
  parameter int RET_DEPTH  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic [CH_ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]    host_wdata,
  input  logic                 ret_pop,
  output logic [DATA_W-1:0]    ret_data,
  output logic                 ret_empty,
  output logic                 ret_full,
  input  logic [NUM_CHAN-1:0]  child_pend,
  input  logic [NUM_CHAN-1:0]  child_avail,
  output logic                 cb_wr,
  output logic [CH_ADDR_W-1:0] cb_waddr,
  output logic [DATA_W-1:0]    cb_wdata,
  output logic                 cb_rd,
  output logic [CH_ADDR_W-1:0] cb_raddr,
  input  logic [DATA_W-1:0]    cb_rdata
);
  // named internal events, used by the checker
  logic              req_hit;
  logic              hold_full, hold_empty, queue_push, direct_wr, drain_pop;
  logic [DATA_W-1:0] hold_head, ret_head;
  logic              pull;
  logic [CHAN_W-1:0] pull_ch;

  assign req_hit = host_wr && in_window(host_addr);

  cr_fifo #(.W(DATA_W), .DEPTH(HOLD_DEPTH)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (queue_push),
    .pop   (drain_pop),
    .din   (host_wdata),
    .dout  (hold_head),
    .empty (hold_empty),
    .full  (hold_full)
  );

  cr_route #(.NUM_CHAN(NUM_CHAN)) u_route (
    .req_hit    (req_hit),
    .req_word   (host_wdata),
    .hold_full  (hold_full),
    .hold_empty (hold_empty),
    .hold_head  (hold_head),
    .child_pend (child_pend),
    .queue_push (queue_push),
    .direct_wr  (direct_wr),
    .drain_pop  (drain_pop),
    .wr_en      (cb_wr),
    .wr_addr    (cb_waddr),
    .wr_data    (cb_wdata)
  );

  cr_collect #(.NUM_CHAN(NUM_CHAN)) u_collect (
    .child_avail (child_avail),
    .ret_full    (ret_full),
    .pull        (pull),
    .pull_ch     (pull_ch)
  );

  assign cb_rd    = pull;
  assign cb_raddr = slot_addr(pull_ch);

  cr_fifo #(.W(DATA_W), .DEPTH(RET_DEPTH)) u_ret (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (pull),
    .pop   (ret_pop),
    .din   (cb_rdata),
    .dout  (ret_head),
    .empty (ret_empty),
    .full  (ret_full)
  );

  assign ret_data = ret_empty ? INVALID_WORD : ret_head;
endmodule

// File: rtl/chan_req_router_chk.sv
module chan_req_router_chk
  import cr_pkg::*;
#(
  parameter int NUM_CHAN = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 host_wr,
  input logic [DATA_W-1:0]    host_wdata,
  input logic [DATA_W-1:0]    ret_data,
  input logic                 ret_empty,
  input logic                 ret_full,
  input logic [NUM_CHAN-1:0]  child_pend,
  input logic [NUM_CHAN-1:0]  child_avail,
  input logic                 cb_wr,
  input logic [CH_ADDR_W-1:0] cb_waddr,
  input logic [DATA_W-1:0]    cb_wdata,
  input logic                 cb_rd,
  input logic [CH_ADDR_W-1:0] cb_raddr,
  input logic [DATA_W-1:0]    cb_rdata,
  input logic                 req_hit,
  input logic                 hold_full
);
  logic [CHAN_W-1:0]   wch, rch, hch;
  logic [NUM_CHAN-1:0] below_r;
  logic                hit_idle;

  always_comb begin
    wch      = cb_waddr[CH_ADDR_W-1:SLOT_SHIFT];
    rch      = cb_raddr[CH_ADDR_W-1:SLOT_SHIFT];
    hch      = host_wdata[CHAN_W-1:0];
    below_r  = (NUM_CHAN'(1) << rch) - NUM_CHAN'(1);
    hit_idle = req_hit && !hold_full && (int'(hch) < NUM_CHAN) && !child_pend[hch];
  end

  // R2
  wr_chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cb_wr |-> (int'(wch) < NUM_CHAN) && (cb_waddr[SLOT_SHIFT-1:0] == '0));

  // R4
  no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cb_wr |-> !child_pend[wch]);

  // R3
  direct_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_idle |-> cb_wr && (cb_wdata == host_wdata) && (wch == hch));

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && hold_full && !cb_wr) |=> hold_full);

  // R7
  pull_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cb_rd |-> child_avail[rch] && ((child_avail & below_r) == '0));

  // R7
  pull_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|child_avail) && !ret_full) |-> cb_rd);

  // R7
  rdata_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cb_rd |-> (cb_rdata != INVALID_WORD));

  // R8
  no_pull_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_full |-> !cb_rd);

  // R9
  empty_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_empty |-> (ret_data == INVALID_WORD));

  // R1
  host_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit |-> host_wr);
endmodule

bind chan_req_router chan_req_router_chk #(.NUM_CHAN(NUM_CHAN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_wr     (host_wr),
  .host_wdata  (host_wdata),
  .ret_data    (ret_data),
  .ret_empty   (ret_empty),
  .ret_full    (ret_full),
  .child_pend  (child_pend),
  .child_avail (child_avail),
  .cb_wr       (cb_wr),
  .cb_waddr    (cb_waddr),
  .cb_wdata    (cb_wdata),
  .cb_rd       (cb_rd),
  .cb_raddr    (cb_raddr),
  .cb_rdata    (cb_rdata),
  .req_hit     (req_hit),
  .hold_full   (hold_full)
);

// File: tb/chan_req_router_bench.sv
module chan_req_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 9;
  localparam int RDEP = 48;
  localparam int LOGN = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        ret_pop = 1'b0;
  logic [31:0] ret_data;
  logic        ret_empty, ret_full;
  logic [NCH-1:0] child_pend = '0;
  logic [NCH-1:0] child_avail;
  logic        cb_wr, cb_rd;
  logic [7:0]  cb_waddr, cb_raddr;
  logic [31:0] cb_wdata, cb_rdata;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_req_router u_chan_req_router (
    .clk (clk), .rst_n (rst_n),
    .host_wr (host_wr), .host_addr (host_addr), .host_wdata (host_wdata),
    .ret_pop (ret_pop), .ret_data (ret_data), .ret_empty (ret_empty), .ret_full (ret_full),
    .child_pend (child_pend), .child_avail (child_avail),
    .cb_wr (cb_wr), .cb_waddr (cb_waddr), .cb_wdata (cb_wdata),
    .cb_rd (cb_rd), .cb_raddr (cb_raddr), .cb_rdata (cb_rdata)
  );

  // child model: response lists and a write log
  logic [31:0] resp [NCH][RDEP];
  int          rcnt [NCH];
  int          rptr [NCH];
  logic [31:0] wlog_d [LOGN];
  logic [7:0]  wlog_a [LOGN];
  int          wcount;

  initial for (int c = 0; c < NCH; c++) rcnt[c] = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) rptr[c] <= 0;
      wcount <= 0;
    end else begin
      if (cb_rd && int'(cb_raddr[7:4]) < NCH) rptr[cb_raddr[7:4]] <= rptr[cb_raddr[7:4]] + 1;
      if (cb_wr && wcount < LOGN) begin
        wlog_d[wcount] <= cb_wdata;
        wlog_a[wcount] <= cb_waddr;
        wcount <= wcount + 1;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) child_avail[c] = rptr[c] < rcnt[c];
    cb_rdata = 32'h0;
    if (int'(cb_raddr[7:4]) < NCH && rptr[cb_raddr[7:4]] < RDEP)
      cb_rdata = resp[cb_raddr[7:4]][rptr[cb_raddr[7:4]]];
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic load(input int ch, input logic [31:0] v);
    resp[ch][rcnt[ch]] = v;
    rcnt[ch] = rcnt[ch] + 1;
  endtask

  // drive one host write; check the same-cycle child write strobe
  task automatic host_write(input logic [7:0] a, input logic [31:0] d, input logic exp_wr, input string tag);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    #1;
    check(cb_wr == exp_wr, tag, {31'b0, cb_wr}, {31'b0, exp_wr});
    if (exp_wr) begin
      check(cb_waddr == {d[3:0], 4'h0}, tag, {24'b0, cb_waddr}, {24'b0, d[3:0], 4'h0});
      check(cb_wdata == d, tag, cb_wdata, d);
    end
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic pop_expect(input logic [31:0] exp, input string tag);
    @(negedge clk);
    check(!ret_empty && ret_data == exp, tag, ret_data, exp);
    ret_pop = 1'b1;
    @(negedge clk);
    ret_pop = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(ret_empty == 1'b1, "R10 empty after reset", {31'b0, ret_empty}, 32'h1);
    check(ret_data == 32'h0F, "R9 marker when empty", ret_data, 32'h0F);
    check(!cb_wr && !cb_rd, "R10 no strobes", {30'b0, cb_wr, cb_rd}, 32'h0);
    repeat (3) @(negedge clk);
    check(wcount == 0, "R10 idle hold FIFO", wcount, 0);
  endtask

  task automatic t_direct;
    host_write(8'hA0, 32'hCAFE_0011, 1'b1, "R3 ch1 direct");
    host_write(8'hAC, 32'h1234_5678, 1'b1, "R3 ch8 direct");
    host_write(8'hA8, 32'h0000_0100, 1'b1, "R3 ch0 direct");
  endtask

  task automatic t_window;
    int w0;
    w0 = wcount;
    host_write(8'h90, 32'h5555_0002, 1'b0, "R1 below window");
    host_write(8'hB0, 32'h5555_0002, 1'b0, "R1 above window");
    host_write(8'hA2, 32'h5555_0002, 1'b0, "R1 unaligned");
    repeat (3) @(negedge clk);
    check(wcount == w0, "R1 nothing queued", wcount, w0);
  endtask

  task automatic t_badchan;
    int w0;
    w0 = wcount;
    host_write(8'hA4, 32'h7777_0009, 1'b0, "R2 ch9");
    host_write(8'hA4, 32'h7777_000F, 1'b0, "R2 ch15");
    repeat (3) @(negedge clk);
    check(wcount == w0, "R2 nothing queued", wcount, w0);
  endtask

  task automatic t_busy;
    int w0;
    w0 = wcount;
    @(negedge clk); child_pend[3] = 1'b1;
    host_write(8'hA0, 32'hAAAA_0003, 1'b0, "R4 busy queue A");
    host_write(8'hA0, 32'hBBBB_0003, 1'b0, "R4 busy queue B");
    host_write(8'hA0, 32'hCCCC_0000, 1'b1, "R3 idle bypass");
    repeat (2) @(negedge clk);
    check(wcount == w0 + 1, "R4 held while busy", wcount, w0 + 1);
    child_pend[3] = 1'b0;
    repeat (4) @(negedge clk);
    check(wcount == w0 + 3, "R6 drained count", wcount, w0 + 3);
    check(wlog_d[w0+1] == 32'hAAAA_0003, "R6 first out", wlog_d[w0+1], 32'hAAAA_0003);
    check(wlog_d[w0+2] == 32'hBBBB_0003, "R6 second out", wlog_d[w0+2], 32'hBBBB_0003);
    check(wlog_a[w0+2] == 8'h30, "R6 slot addr", {24'b0, wlog_a[w0+2]}, 32'h30);
  endtask

  task automatic t_overflow;
    int w0;
    w0 = wcount;
    @(negedge clk); child_pend[5] = 1'b1;
    for (int i = 0; i < 33; i++)
      host_write(8'hA4, 32'hB000_0005 | (i << 8), 1'b0, "R5 fill");
    child_pend[5] = 1'b0;
    repeat (40) @(negedge clk);
    check(wcount == w0 + 32, "R5 overflow dropped", wcount, w0 + 32);
    check(wlog_d[w0] == 32'hB000_0005, "R5 head kept", wlog_d[w0], 32'hB000_0005);
    check(wlog_d[w0+31] == (32'hB000_0005 | (31 << 8)), "R5 last kept",
          wlog_d[w0+31], 32'hB000_0005 | (31 << 8));
  endtask

  task automatic t_collect;
    @(negedge clk);
    load(8, 32'h8000_0001); load(8, 32'h8000_0002);
    load(3, 32'h3000_0001); load(0, 32'h0000_1000);
    repeat (6) @(negedge clk);
    check(!cb_rd, "R7 idle after drain", {31'b0, cb_rd}, 32'h0);
    pop_expect(32'h0000_1000, "R7 ch0 first");
    pop_expect(32'h3000_0001, "R7 ch3 second");
    pop_expect(32'h8000_0001, "R9 ch8 order a");
    pop_expect(32'h8000_0002, "R9 ch8 order b");
    check(ret_empty && ret_data == 32'h0F, "R9 marker after drain", ret_data, 32'h0F);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    for (int i = 0; i < 40; i++) load(2, 32'h2200_0000 + i * 16);
    repeat (40) @(negedge clk);
    check(ret_full == 1'b1, "R8 return full", {31'b0, ret_full}, 32'h1);
    check(child_avail[2] && !cb_rd, "R8 held back", {30'b0, child_avail[2], cb_rd}, 32'h2);
    for (int i = 0; i < 40; i++) pop_expect(32'h2200_0000 + i * 16, "R8 resumed order");
    check(ret_empty, "R8 all delivered", {31'b0, ret_empty}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_direct;
    t_window;
    t_badchan;
    t_busy;
    t_overflow;
    t_collect;
    t_backpressure;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule